// File: doc/BRIEF.md
# Pipeline Back-End Bypass Controller

This block runs the execute-to-write-back end of a five-stage in-order pipeline and cuts switching activity there. Each cycle the execute stage presents one instruction: a class code, the execute result, the store data, a destination register number and a write-enable. The block holds the EX/MEM and MEM/WB pipeline registers. It issues requests to a data memory of 256 locations, which takes an 8-bit address, and it drives the register-file write port.

A one-bit mode flag decides which path each instruction takes. A store, a branch or a jump sets the flag, and a load clears it. While the flag is set, arithmetic results skip the memory stage and are written to the register file one cycle early. Every instruction that does not touch memory then leaves the EX/MEM register at all-zero, so that register does not toggle. Loads and stores always take the regular path. Each instruction that writes back does so exactly once, and program order is kept.

Top module: `pipe_bypass_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mode flag, the EX/MEM and MEM/WB registers and the early write-back register. Once reset is released, no register-file write or memory request is driven until an instruction arrives.
- R2: The class codes are 0 bubble, 1 arithmetic, 2 load, 3 store, 4 branch and 5 jump. Codes 6 and 7 act as bubbles. A store, branch or jump presented in cycle t sets `bypass_mode` in cycle t+1.
- R3: A load presented in cycle t clears `bypass_mode` in cycle t+1. Any other class leaves it unchanged.
- R4: An arithmetic instruction presented while `bypass_mode` is high, with write-enable set and a nonzero destination, writes the register file in cycle t+1 with its destination and execute result.
- R5: Any instruction other than a load or store presented while `bypass_mode` is high leaves every EX/MEM field (class, result, store data, destination, write-enable) at zero in cycle t+1.
- R6: Loads and stores, and every instruction presented while `bypass_mode` is low, are held in the EX/MEM register in cycle t+1. An arithmetic or load instruction on this path writes the register file in cycle t+2.
- R7: In cycle t+1, a load drives `dmem_re`, and a store drives `dmem_we` with its store data. Both use bits 7:0 of the execute result as `dmem_addr`. A load writes back the `dmem_rdata` value present in cycle t+1.
- R8: Stores, branches, jumps and bubbles never write the register file.
- R9: An instruction with write-enable low or destination 0 never writes the register file.
- R10: Every qualifying instruction writes the register file exactly once, in program order, with at most one write per cycle. If an early write and a regular write meet in one cycle, the regular write goes first and the early one is held for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_class | input | 3 | Class code of the instruction leaving execute |
| ex_result | input | 32 | Execute-stage result (also the memory address) |
| ex_store_data | input | 32 | Data to store |
| ex_dest | input | 5 | Destination register number |
| ex_wr_en | input | 1 | Instruction wants a register write |
| bypass_mode | output | 1 | Mode flag |
| exmem_class | output | 3 | EX/MEM register: class |
| exmem_result | output | 32 | EX/MEM register: result |
| exmem_store_data | output | 32 | EX/MEM register: store data |
| exmem_dest | output | 5 | EX/MEM register: destination |
| exmem_wr_en | output | 1 | EX/MEM register: write-enable |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_rdata | input | 32 | Data memory read data, same cycle |
| memwb_wr_en | output | 1 | MEM/WB register: write pending |
| memwb_dest | output | 5 | MEM/WB register: destination |
| memwb_data | output | 32 | MEM/WB register: data |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 5 | Register-file write address |
| rf_data | output | 32 | Register-file write data |

## Verification
Each result has a fixed due cycle, counted from the cycle its instruction is presented. The mode flag, the EX/MEM contents and the memory request are due one cycle later. A bypassed arithmetic write is due one cycle later and a regular-path write two cycles later. At each input, the driver works out these due cycles from its own model of the mode flag and of memory contents, then queues the expected register writes, stores and zero-EX/MEM events with their due stamps. The monitor samples on the falling edge and requires each observed write or store to match the head of its queue in content and in cycle. This makes a write that is early, late, repeated or out of order a failure, and random streams are checked against a pipeline model that never bypasses.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_JUMP   = 3'd5
  } instr_cls_e;

  // store, branch or jump turn the bypass mode on
  function automatic logic sets_mode(input logic [CLS_W-1:0] c);
    return (c == CLS_STORE) || (c == CLS_BRANCH) || (c == CLS_JUMP);
  endfunction

  function automatic logic clears_mode(input logic [CLS_W-1:0] c);
    return c == CLS_LOAD;
  endfunction

  function automatic logic next_mode(input logic cur, input logic [CLS_W-1:0] c);
    logic nxt;
    nxt = cur;
    if (clears_mode(c))    nxt = 1'b0;
    else if (sets_mode(c)) nxt = 1'b1;
    return nxt;
  endfunction

  // instructions that really use the memory stage
  function automatic logic needs_mem(input logic [CLS_W-1:0] c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

  function automatic logic produces_wb(input logic [CLS_W-1:0] c);
    return (c == CLS_ALU) || (c == CLS_LOAD);
  endfunction

  // a register-file write is really wanted (r0 is never written)
  function automatic logic wb_allowed(input logic [CLS_W-1:0] c, input logic we,
                                      input logic [7:0] dest);
    return produces_wb(c) && we && (dest != 8'd0);
  endfunction

endpackage

// File: rtl/bpc_mode_tracker.sv
module bpc_mode_tracker
  import bpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] cls_i,
  output logic             mode_o,
  output logic             route_early_o
);

  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= next_mode(mode_q, cls_i);
  end

  assign mode_o        = mode_q;
  assign route_early_o = mode_q && (cls_i == CLS_ALU);

  a_r2_mode_set: assert property (@(posedge clk) disable iff (rst)
    sets_mode(cls_i) |=> mode_o);

  a_r3_mode_clear: assert property (@(posedge clk) disable iff (rst)
    clears_mode(cls_i) |=> !mode_o);

  a_r3_mode_keep: assert property (@(posedge clk) disable iff (rst)
    (!sets_mode(cls_i) && !clears_mode(cls_i)) |=> $stable(mode_o));

endmodule

// File: rtl/bpc_exmem_stage.sv
module bpc_exmem_stage
  import bpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] sdata_i,
  input  logic [REG_AW-1:0] dest_i,
  input  logic              we_i,
  output logic [CLS_W-1:0]  cls_o,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] sdata_o,
  output logic [REG_AW-1:0] dest_o,
  output logic              we_o
);

  // in bypass mode only memory users may occupy the register
  logic zero_gate_w;
  assign zero_gate_w = mode_i && !needs_mem(cls_i);

  always_ff @(posedge clk) begin
    if (rst || zero_gate_w) begin
      cls_o    <= '0;
      result_o <= '0;
      sdata_o  <= '0;
      dest_o   <= '0;
      we_o     <= 1'b0;
    end else begin
      cls_o    <= cls_i;
      result_o <= result_i;
      sdata_o  <= sdata_i;
      dest_o   <= dest_i;
      we_o     <= we_i;
    end
  end

  a_r6_regular_capture: assert property (@(posedge clk) disable iff (rst)
    (!mode_i || needs_mem(cls_i)) |=> (cls_o == $past(cls_i)) && (dest_o == $past(dest_i)));

endmodule

// File: rtl/bpc_mem_stage.sv
module bpc_mem_stage
  import bpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CLS_W-1:0]  exm_cls_i,
  input  logic [DATA_W-1:0] exm_result_i,
  input  logic [DATA_W-1:0] exm_sdata_i,
  input  logic [REG_AW-1:0] exm_dest_i,
  input  logic              exm_we_i,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  output logic [MEM_AW-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  output logic              dmem_we_o,
  output logic              dmem_re_o,
  output logic              memwb_we_o,
  output logic [REG_AW-1:0] memwb_dest_o,
  output logic [DATA_W-1:0] memwb_data_o
);

  logic              is_load_w;
  logic              is_store_w;
  logic              wb_ok_w;
  logic [DATA_W-1:0] wb_data_w;

  assign is_load_w  = (exm_cls_i == CLS_LOAD);
  assign is_store_w = (exm_cls_i == CLS_STORE);
  assign wb_ok_w    = wb_allowed(exm_cls_i, exm_we_i, 8'(exm_dest_i));
  assign wb_data_w  = is_load_w ? dmem_rdata_i : exm_result_i;

  // memory request lines stay quiet unless a memory user is present
  assign dmem_addr_o  = needs_mem(exm_cls_i) ? exm_result_i[MEM_AW-1:0] : '0;
  assign dmem_wdata_o = is_store_w ? exm_sdata_i : '0;
  assign dmem_we_o    = is_store_w;
  assign dmem_re_o    = is_load_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_we_o   <= 1'b0;
      memwb_dest_o <= '0;
      memwb_data_o <= '0;
    end else begin
      memwb_we_o   <= wb_ok_w;
      memwb_dest_o <= wb_ok_w ? exm_dest_i : '0;
      memwb_data_o <= wb_ok_w ? wb_data_w : '0;
    end
  end

  a_r8_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    !produces_wb(exm_cls_i) |=> !memwb_we_o);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we_o && dmem_re_o));

endmodule

// File: rtl/bpc_wb_select.sv
module bpc_wb_select #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              early_req_i,
  input  logic [REG_AW-1:0] early_dest_i,
  input  logic [DATA_W-1:0] early_data_i,
  input  logic              memwb_we_i,
  input  logic [REG_AW-1:0] memwb_dest_i,
  input  logic [DATA_W-1:0] memwb_data_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o
);

  logic              early_we_q;
  logic [REG_AW-1:0] early_dest_q;
  logic [DATA_W-1:0] early_data_q;
  logic              hold_w;

  // regular path wins a shared slot; the early result waits a cycle
  assign hold_w = early_we_q && memwb_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_we_q   <= 1'b0;
      early_dest_q <= '0;
      early_data_q <= '0;
    end else if (!hold_w) begin
      early_we_q   <= early_req_i;
      early_dest_q <= early_req_i ? early_dest_i : '0;
      early_data_q <= early_req_i ? early_data_i : '0;
    end
  end

  assign rf_we_o   = memwb_we_i || early_we_q;
  assign rf_addr_o = memwb_we_i ? memwb_dest_i : early_dest_q;
  assign rf_data_o = memwb_we_i ? memwb_data_i : early_data_q;

  a_r9_no_reg0: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_addr_o != '0));

  a_r10_hold_early: assert property (@(posedge clk) disable iff (rst)
    hold_w |=> early_we_q && $stable(early_data_q) && $stable(early_dest_q));

  a_r10_no_overrun: assert property (@(posedge clk) disable iff (rst)
    hold_w |-> !early_req_i);

endmodule

// File: rtl/pipe_bypass_ctrl.sv
module pipe_bypass_ctrl
  import bpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ex_class,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [DATA_W-1:0] ex_store_data,
  input  logic [REG_AW-1:0] ex_dest,
  input  logic              ex_wr_en,
  output logic              bypass_mode,
  output logic [2:0]        exmem_class,
  output logic [DATA_W-1:0] exmem_result,
  output logic [DATA_W-1:0] exmem_store_data,
  output logic [REG_AW-1:0] exmem_dest,
  output logic              exmem_wr_en,
  output logic [MEM_AW-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  output logic              dmem_re,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              memwb_wr_en,
  output logic [REG_AW-1:0] memwb_dest,
  output logic [DATA_W-1:0] memwb_data,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_data
);

  logic route_early_w;
  logic early_req_w;

  bpc_mode_tracker u_mode (
    .clk           (clk),
    .rst           (rst),
    .cls_i         (ex_class),
    .mode_o        (bypass_mode),
    .route_early_o (route_early_w)
  );

  assign early_req_w = route_early_w && wb_allowed(ex_class, ex_wr_en, 8'(ex_dest));

  bpc_exmem_stage #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_exmem (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (bypass_mode),
    .cls_i    (ex_class),
    .result_i (ex_result),
    .sdata_i  (ex_store_data),
    .dest_i   (ex_dest),
    .we_i     (ex_wr_en),
    .cls_o    (exmem_class),
    .result_o (exmem_result),
    .sdata_o  (exmem_store_data),
    .dest_o   (exmem_dest),
    .we_o     (exmem_wr_en)
  );

  bpc_mem_stage #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_mem (
    .clk          (clk),
    .rst          (rst),
    .exm_cls_i    (exmem_class),
    .exm_result_i (exmem_result),
    .exm_sdata_i  (exmem_store_data),
    .exm_dest_i   (exmem_dest),
    .exm_we_i     (exmem_wr_en),
    .dmem_rdata_i (dmem_rdata),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_re_o    (dmem_re),
    .memwb_we_o   (memwb_wr_en),
    .memwb_dest_o (memwb_dest),
    .memwb_data_o (memwb_data)
  );

  bpc_wb_select #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_wb (
    .clk          (clk),
    .rst          (rst),
    .early_req_i  (early_req_w),
    .early_dest_i (ex_dest),
    .early_data_i (ex_result),
    .memwb_we_i   (memwb_wr_en),
    .memwb_dest_i (memwb_dest),
    .memwb_data_i (memwb_data),
    .rf_we_o      (rf_we),
    .rf_addr_o    (rf_addr),
    .rf_data_o    (rf_data)
  );

  a_r4_early_write: assert property (@(posedge clk) disable iff (rst)
    (early_req_w && !memwb_wr_en) |=>
      rf_we && (rf_addr == $past(ex_dest)) && (rf_data == $past(ex_result)));

  a_r5_exmem_quiet: assert property (@(posedge clk) disable iff (rst)
    (bypass_mode && !needs_mem(ex_class)) |=>
      (exmem_class == '0) && (exmem_result == '0) && (exmem_store_data == '0) &&
      (exmem_dest == '0) && !exmem_wr_en);

  a_r1_idle_quiet: assert property (@(posedge clk)
    $past(rst) |-> !rf_we && !dmem_we && !dmem_re && !bypass_mode);

endmodule

// File: tb/pipe_bypass_ctrl_tb.sv
module pipe_bypass_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ex_class = '0;
  logic [31:0] ex_result = '0;
  logic [31:0] ex_store_data = '0;
  logic [4:0]  ex_dest = '0;
  logic        ex_wr_en = 1'b0;
  logic        bypass_mode;
  logic [2:0]  exmem_class;
  logic [31:0] exmem_result, exmem_store_data;
  logic [4:0]  exmem_dest;
  logic        exmem_wr_en;
  logic [7:0]  dmem_addr;
  logic [31:0] dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic        memwb_wr_en;
  logic [4:0]  memwb_dest;
  logic [31:0] memwb_data;
  logic        rf_we;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data;

  always #2.5 clk = ~clk;

  pipe_bypass_ctrl dut_i (
    .clk(clk), .rst(rst), .ex_class(ex_class), .ex_result(ex_result),
    .ex_store_data(ex_store_data), .ex_dest(ex_dest), .ex_wr_en(ex_wr_en),
    .bypass_mode(bypass_mode), .exmem_class(exmem_class), .exmem_result(exmem_result),
    .exmem_store_data(exmem_store_data), .exmem_dest(exmem_dest), .exmem_wr_en(exmem_wr_en),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata), .memwb_wr_en(memwb_wr_en), .memwb_dest(memwb_dest),
    .memwb_data(memwb_data), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data)
  );

  // environment memory seen by the design
  logic [31:0] env_mem [256];
  always @(posedge clk) if (dmem_we) env_mem[dmem_addr] <= dmem_wdata;
  assign dmem_rdata = env_mem[dmem_addr];

  typedef struct packed { logic [4:0] r; logic [31:0] d; logic [31:0] due; } wb_item_t;
  typedef struct packed { logic [7:0] a; logic [31:0] d; logic [31:0] due; } st_item_t;

  wb_item_t    wb_q[$];
  st_item_t    st_q[$];
  logic [31:0] zero_q[$];

  logic [31:0] ref_mem [256];
  logic        exp_mode = 1'b0;
  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_err = 0;
  bit          mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic report_end();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // reference model: no bypass, program-ordered effects; timing stamped per path
  task automatic issue(input logic [2:0] c, input logic [31:0] res, input logic [31:0] sd,
                       input logic [4:0] dst, input logic we);
    bit byp;
    bit memuse;
    @(negedge clk);
    chk(bypass_mode == exp_mode, "R2/R3", "mode flag", 64'(bypass_mode), 64'(exp_mode));
    ex_class = c; ex_result = res; ex_store_data = sd; ex_dest = dst; ex_wr_en = we;
    byp    = exp_mode;
    memuse = (c == 3'd2) || (c == 3'd3);
    if (byp && !memuse) zero_q.push_back(cyc + 1);
    if ((c == 3'd1 || c == 3'd2) && we && dst != 5'd0) begin
      wb_item_t it;
      it.r   = dst;
      it.d   = (c == 3'd2) ? ref_mem[res[7:0]] : res;
      it.due = cyc + ((byp && c == 3'd1) ? 1 : 2);
      wb_q.push_back(it);
    end
    if (c == 3'd3) begin
      st_item_t s;
      s.a = res[7:0]; s.d = sd; s.due = cyc + 1;
      st_q.push_back(s);
      ref_mem[res[7:0]] = sd;
    end
    if (c == 3'd2) exp_mode = 1'b0;
    else if (c == 3'd3 || c == 3'd4 || c == 3'd5) exp_mode = 1'b1;
  endtask

  // monitor: compare design results against due-stamped expectations
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (wb_q.size() != 0 && wb_q[0].due < cyc) begin
        chk(1'b0, "R10", "missing register write", 64'(0), 64'(wb_q[0].r));
        void'(wb_q.pop_front());
      end
      if (rf_we) begin
        if (wb_q.size() == 0) begin
          chk(1'b0, "R8/R9", "unexpected register write", 64'(rf_addr), 64'(0));
        end else begin
          wb_item_t e;
          e = wb_q.pop_front();
          chk(rf_addr == e.r, "R10", "write order/register", 64'(rf_addr), 64'(e.r));
          chk(rf_data == e.d, "R7/R10", "write data", 64'(rf_data), 64'(e.d));
          chk(cyc == e.due, "R4/R6", "write cycle", 64'(cyc), 64'(e.due));
        end
      end
      if (st_q.size() != 0 && st_q[0].due < cyc) begin
        chk(1'b0, "R7", "missing store", 64'(0), 64'(st_q[0].a));
        void'(st_q.pop_front());
      end
      if (dmem_we) begin
        if (st_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected store", 64'(dmem_addr), 64'(0));
        end else begin
          st_item_t s;
          s = st_q.pop_front();
          chk(dmem_addr == s.a, "R7", "store address", 64'(dmem_addr), 64'(s.a));
          chk(dmem_wdata == s.d, "R7", "store data", 64'(dmem_wdata), 64'(s.d));
          chk(cyc == s.due, "R7", "store cycle", 64'(cyc), 64'(s.due));
        end
      end
      if (zero_q.size() != 0 && zero_q[0] == cyc) begin
        void'(zero_q.pop_front());
        chk({exmem_class, exmem_result, exmem_store_data, exmem_dest, exmem_wr_en} == '0,
            "R5", "EX/MEM not zero in bypass", 64'(exmem_result), 64'(0));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 60000) begin
        chk(1'b0, "WDOG", "watchdog expired", 64'(cyc), 64'(60000));
        report_end();
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      env_mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!bypass_mode, "R1", "mode after reset", 64'(bypass_mode), 64'(0));
    chk({exmem_class, exmem_result, exmem_dest, exmem_wr_en} == '0, "R1", "EX/MEM after reset",
        64'(exmem_result), 64'(0));
    chk(!rf_we && !memwb_wr_en && !dmem_we && !dmem_re, "R1", "no activity after reset",
        64'({rf_we, memwb_wr_en, dmem_we, dmem_re}), 64'(0));
    mon_on = 1'b1;

    // R6: regular path
    issue(3'd1, 32'h0000_1111, 32'h0, 5'd1, 1'b1);
    issue(3'd1, 32'h0000_2222, 32'h0, 5'd2, 1'b1);
    // R2: store sets mode, R7 store request
    issue(3'd3, 32'h0000_0010, 32'hCAFE_0001, 5'd0, 1'b0);
    // R4: bypassed arithmetic, back to back
    issue(3'd1, 32'h0000_3333, 32'h0, 5'd3, 1'b1);
    issue(3'd1, 32'h0000_4444, 32'h0, 5'd4, 1'b1);
    // R9: destination 0 and write-enable low
    issue(3'd1, 32'h0000_5555, 32'h0, 5'd0, 1'b1);
    issue(3'd1, 32'h0000_6666, 32'h0, 5'd5, 1'b0);
    // R8: branch, jump, bubble, code 7 give no write
    issue(3'd4, 32'h0000_7777, 32'h0, 5'd6, 1'b1);
    issue(3'd5, 32'h0000_8888, 32'h0, 5'd7, 1'b1);
    issue(3'd0, 32'h0000_9999, 32'h0, 5'd8, 1'b1);
    issue(3'd7, 32'h0000_AAAA, 32'h0, 5'd9, 1'b1);
    // R3/R7: load in bypass clears mode, reads stored value
    issue(3'd2, 32'h0000_0010, 32'h0, 5'd10, 1'b1);
    issue(3'd1, 32'h0000_BBBB, 32'h0, 5'd11, 1'b1);
    // store in bypass, then load of same address
    issue(3'd5, 32'h0, 32'h0, 5'd0, 1'b0);
    issue(3'd3, 32'h0000_0020, 32'hBEEF_0002, 5'd0, 1'b0);
    issue(3'd1, 32'h0000_CCCC, 32'h0, 5'd12, 1'b1);
    issue(3'd2, 32'h0000_0020, 32'h0, 5'd13, 1'b1);
    issue(3'd2, 32'h0000_0010, 32'h0, 5'd14, 1'b1);
    for (int k = 0; k < 4; k++) issue(3'd0, 32'h0, 32'h0, 5'd0, 1'b0);

    // random streams against the non-bypassing reference (R10)
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  c;
      logic [31:0] res;
      int          pick;
      pick = $urandom_range(0, 9);
      case (pick)
        4: c = 3'd2;
        5: c = 3'd3;
        6: c = 3'd4;
        7: c = 3'd5;
        8: c = 3'd0;
        default: c = 3'd1;
      endcase
      res = $urandom;
      if (c == 3'd2 || c == 3'd3) res[7:0] = 8'($urandom_range(0, 15));
      issue(c, res, $urandom, 5'($urandom_range(0, 7)), $urandom_range(0, 7) != 0);
    end
    for (int k = 0; k < 5; k++) issue(3'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    @(negedge clk);
    chk(wb_q.size() == 0, "R10", "writes left pending", 64'(wb_q.size()), 64'(0));
    chk(st_q.size() == 0, "R7", "stores left pending", 64'(st_q.size()), 64'(0));
    report_end();
  end

endmodule